// File: doc/BRIEF.md
# Register Status Table with Uncommitted-Result State

This block sits between the issue stage and the commit stage of an out-of-order core. For every architectural register it keeps a status, a current-writer tag (an index into the reorder buffer) and the committed value. An instruction being issued names up to two source registers. For each source the block answers in the same cycle whether the operand can be taken from the register file, must be awaited on the result bus under a tag, or can be fetched from the reorder buffer at an index. The same issue also claims one destination register for the new tag.

Results broadcast on the result bus mark a register as holding an uncommitted result without touching the register file. Commits write the register file. A misprediction flush returns every register to the committed state. Every status change is guarded by a comparison against the current writer, so an older instruction never undoes what a newer writer set up. The reservation stations and the reorder buffer storage lie outside this block.

Top module: `reg_status_table`

## Requirements
- R1: After reset every register is available (kind 0) and holds the value zero.
- R2: A source lookup returns kind 0 with the register file value when the register is available, kind 1 with the writer tag when its writer is in flight, and kind 2 with the writer tag as a reorder buffer index when the result is ready but uncommitted. Kind 3 never appears.
- R3: An issue with the destination enable set makes the destination in-flight (kind 1) with the new tag as writer from the next cycle on, replacing any earlier writer and any earlier state. With the enable clear, no register changes.
- R4: A result broadcast whose tag equals the current writer of an in-flight register makes it ready (kind 2) from the next cycle on. The register file value is unchanged.
- R5: A result broadcast whose tag differs from the current writer leaves that register's state and writer unchanged.
- R6: A commit always writes its value into the named register of the file. The register becomes available only when the commit tag equals its current writer. Otherwise its state stays as it was.
- R7: A flush makes every register available in the next cycle. An issue in the flush cycle is dropped. A commit in the flush cycle still writes its value.
- R8: Source lookups see the state before any update made in the same cycle, including a source that names the destination of the same instruction.
- R9: A result and a commit to the same register in one cycle are both applied. When both tags match the writer, the register ends available with the committed value.
- R10: When an issue to a register falls in the same cycle as a matching result or commit for that register, the issue wins: the register ends in-flight under the new tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is being issued this cycle |
| iss_src0 | input | IDX_W | First source register |
| iss_src1 | input | IDX_W | Second source register |
| iss_dst_en | input | 1 | The issued instruction writes a register |
| iss_dst | input | IDX_W | Destination register |
| iss_tag | input | TAG_W | Reorder buffer tag of the issued instruction |
| res_valid | input | 1 | Result bus broadcast this cycle |
| res_tag | input | TAG_W | Tag on the result bus |
| cmt_valid | input | 1 | Commit this cycle |
| cmt_tag | input | TAG_W | Tag of the committing instruction |
| cmt_reg | input | IDX_W | Register written by the commit |
| cmt_value | input | DATA_W | Committed value |
| flush | input | 1 | Misprediction flush |
| src0_kind | output | 2 | Answer kind for source 0 (0 file, 1 wait, 2 buffer) |
| src0_value | output | DATA_W | Register file value for source 0 |
| src0_tag | output | TAG_W | Writer tag or buffer index for source 0 |
| src1_kind | output | 2 | Answer kind for source 1 |
| src1_value | output | DATA_W | Register file value for source 1 |
| src1_tag | output | TAG_W | Writer tag or buffer index for source 1 |

## Verification
A result broadcast and a commit can hit the same register in the same cycle. Either of them can also coincide with an issue that redirects that register to a new writer. The bench provokes each case from its vector table: a result and a commit both carrying the current writer's tag, a stale result next to a fresh issue, and a commit under a flush with an issue dropped. It judges the outcome by the kind, tag and value the lookups return in the following cycles. Each row also checks the same-cycle lookup against the state before the update, so the ordering within a cycle is visible at the ports.

// File: rtl/rst_pkg.sv
package rst_pkg;

    typedef enum logic [1:0] {
        ST_AVAIL  = 2'd0,
        ST_FLIGHT = 2'd1,
        ST_READY  = 2'd2
    } reg_state_e;

    function automatic logic tag_match(input logic [7:0] a, input logic [7:0] b);
        return a == b;
    endfunction

    function automatic reg_state_e after_result(input reg_state_e cur, input logic hit);
        return (hit && cur == ST_FLIGHT) ? ST_READY : cur;
    endfunction

    function automatic reg_state_e after_commit(input reg_state_e cur, input logic hit);
        return hit ? ST_AVAIL : cur;
    endfunction

endpackage

// File: rtl/rst_state_entry.sv
module rst_state_entry
    import rst_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             iss_hit,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             res_valid,
    input  logic [TAG_W-1:0] res_tag,
    input  logic             cmt_hit,
    input  logic [TAG_W-1:0] cmt_tag,
    output reg_state_e       state,
    output logic [TAG_W-1:0] writer
);

    reg_state_e       st_q, st_n, st_res;
    logic [TAG_W-1:0] wr_q, wr_n;
    logic             res_match, cmt_match;

    always_comb begin
        res_match = res_valid && tag_match(8'(res_tag), 8'(wr_q));
        cmt_match = cmt_hit && tag_match(8'(cmt_tag), 8'(wr_q));
        st_res    = after_result(st_q, res_match);
        st_n      = after_commit(st_res, cmt_match);
        wr_n      = wr_q;
        if (iss_hit) begin
            st_n = ST_FLIGHT;
            wr_n = iss_tag;
        end
        if (flush) begin
            st_n = ST_AVAIL;
            wr_n = wr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_AVAIL;
            wr_q <= '0;
        end else begin
            st_q <= st_n;
            wr_q <= wr_n;
        end
    end

    assign state  = st_q;
    assign writer = wr_q;

endmodule

// File: rtl/rst_regfile.sv
module rst_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 16,
    parameter int NRD    = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [NRD-1:0][IDX_W-1:0]    rd_idx,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data
);

    logic [DATA_W-1:0] mem_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_idx[p]];
    end

endmodule

// File: rtl/rst_src_lookup.sv
module rst_src_lookup
    import rst_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][1:0]       st_bits,
    input  logic [NREG-1:0][TAG_W-1:0] wr_bits,
    input  logic [IDX_W-1:0]           src,
    input  logic [DATA_W-1:0]          file_value,
    output logic [1:0]                 kind,
    output logic [DATA_W-1:0]          value,
    output logic [TAG_W-1:0]           tag
);

    reg_state_e st;

    always_comb begin
        st    = reg_state_e'(st_bits[src]);
        kind  = st;
        tag   = wr_bits[src];
        value = (st == ST_AVAIL) ? file_value : '0;
    end

endmodule

// File: rtl/reg_status_table.sv
module reg_status_table
    import rst_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int NSRC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_src0,
    input  logic [IDX_W-1:0]  iss_src1,
    input  logic              iss_dst_en,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic              cmt_valid,
    input  logic [TAG_W-1:0]  cmt_tag,
    input  logic [IDX_W-1:0]  cmt_reg,
    input  logic [DATA_W-1:0] cmt_value,
    input  logic              flush,
    output logic [1:0]        src0_kind,
    output logic [DATA_W-1:0] src0_value,
    output logic [TAG_W-1:0]  src0_tag,
    output logic [1:0]        src1_kind,
    output logic [DATA_W-1:0] src1_value,
    output logic [TAG_W-1:0]  src1_tag
);

    logic [NREG-1:0][1:0]         st_bits;
    logic [NREG-1:0][TAG_W-1:0]   wr_bits;
    logic [NSRC-1:0][IDX_W-1:0]   src_idx;
    logic [NSRC-1:0][DATA_W-1:0]  src_file;
    logic [NSRC-1:0][1:0]         src_kind;
    logic [NSRC-1:0][DATA_W-1:0]  src_val;
    logic [NSRC-1:0][TAG_W-1:0]   src_tag;
    logic                         iss_claim;

    assign iss_claim  = iss_valid && iss_dst_en && !flush;
    assign src_idx[0] = iss_src0;
    assign src_idx[1] = iss_src1;

    for (genvar r = 0; r < NREG; r++) begin : g_ent
        reg_state_e st_r;
        rst_state_entry #(.TAG_W(TAG_W)) u_ent (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .iss_hit   (iss_claim && iss_dst == IDX_W'(r)),
            .iss_tag   (iss_tag),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .cmt_hit   (cmt_valid && cmt_reg == IDX_W'(r)),
            .cmt_tag   (cmt_tag),
            .state     (st_r),
            .writer    (wr_bits[r])
        );
        assign st_bits[r] = st_r;
    end

    rst_regfile #(.NREG(NREG), .DATA_W(DATA_W), .NRD(NSRC)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmt_valid),
        .wr_idx  (cmt_reg),
        .wr_data (cmt_value),
        .rd_idx  (src_idx),
        .rd_data (src_file)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rst_src_lookup #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lk (
            .st_bits    (st_bits),
            .wr_bits    (wr_bits),
            .src        (src_idx[s]),
            .file_value (src_file[s]),
            .kind       (src_kind[s]),
            .value      (src_val[s]),
            .tag        (src_tag[s])
        );
    end

    assign src0_kind  = src_kind[0];
    assign src0_value = src_val[0];
    assign src0_tag   = src_tag[0];
    assign src1_kind  = src_kind[1];
    assign src1_value = src_val[1];
    assign src1_tag   = src_tag[1];

endmodule

// File: rtl/rst_checker.sv
module rst_checker #(
    parameter int NREG  = 16,
    parameter int TAG_W = 3,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       iss_valid,
    input logic                       iss_dst_en,
    input logic [IDX_W-1:0]           iss_dst,
    input logic [TAG_W-1:0]           iss_tag,
    input logic                       flush,
    input logic [1:0]                 src0_kind,
    input logic [1:0]                 src1_kind,
    input logic [NREG-1:0][1:0]       st_bits,
    input logic [NREG-1:0][TAG_W-1:0] wr_bits
);

    AST_ISSUE_CLAIMS: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_dst_en && !flush) |=>
            (st_bits[$past(iss_dst)] == 2'd1 && wr_bits[$past(iss_dst)] == $past(iss_tag))); // R3

    AST_WRITER_HELD: assert property (@(posedge clk) disable iff (rst)
        !(iss_valid && iss_dst_en) |=> $stable(wr_bits)); // R3

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (st_bits == '0)); // R7

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (src0_kind != 2'd3) && (src1_kind != 2'd3)); // R2

    for (genvar r = 0; r < NREG; r++) begin : g_chk
        AST_READY_ONLY_FROM_FLIGHT: assert property (@(posedge clk) disable iff (rst)
            (st_bits[r] == 2'd0) |=> (st_bits[r] != 2'd2)); // R4
    end

endmodule

bind reg_status_table rst_checker #(.NREG(NREG), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .iss_valid  (iss_valid),
    .iss_dst_en (iss_dst_en),
    .iss_dst    (iss_dst),
    .iss_tag    (iss_tag),
    .flush      (flush),
    .src0_kind  (src0_kind),
    .src1_kind  (src1_kind),
    .st_bits    (st_bits),
    .wr_bits    (wr_bits)
);

// File: tb/sim_reg_status_table.sv
module sim_reg_status_table;

    localparam int CLK_P  = 10;
    localparam int NREG   = 16;
    localparam int TAG_W  = 3;
    localparam int DATA_W = 16;
    localparam int IDX_W  = $clog2(NREG);
    localparam int NSTEP  = 19;

    typedef struct packed {
        logic        iv;
        logic        de;
        logic [3:0]  s0;
        logic [3:0]  s1;
        logic [3:0]  d;
        logic [2:0]  tg;
        logic        rv;
        logic [2:0]  rt;
        logic        cv;
        logic [2:0]  ct;
        logic [3:0]  cr;
        logic [15:0] cval;
        logic        fl;
        logic [1:0]  k0;
        logic [15:0] p0;
        logic [1:0]  k1;
        logic [15:0] p1;
        logic [31:0] req;
    } step_t;

    // kind 0: payload is the file value; kind 1/2: payload is the tag
    localparam step_t TBL [NSTEP] = '{
        '{1'b1,1'b1,4'd4,4'd5,4'd4,3'd1, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd0,16'h0000, 2'd0,16'h0000, "R8  "},
        '{1'b1,1'b1,4'd4,4'd6,4'd8,3'd2, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd1,16'h0001, 2'd0,16'h0000, "R2  "},
        '{1'b0,1'b0,4'd4,4'd8,4'd0,3'd0, 1'b1,3'd1, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd1,16'h0001, 2'd1,16'h0002, "R8  "},
        '{1'b0,1'b0,4'd4,4'd8,4'd0,3'd0, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd2,16'h0001, 2'd1,16'h0002, "R4  "},
        '{1'b1,1'b1,4'd4,4'd4,4'd4,3'd3, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd2,16'h0001, 2'd2,16'h0001, "R8  "},
        '{1'b0,1'b0,4'd4,4'd9,4'd0,3'd0, 1'b1,3'd1, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd1,16'h0003, 2'd0,16'h0000, "R3  "},
        '{1'b0,1'b0,4'd4,4'd9,4'd0,3'd0, 1'b0,3'd0, 1'b1,3'd1,4'd4,16'h1111, 1'b0, 2'd1,16'h0003, 2'd0,16'h0000, "R5  "},
        '{1'b0,1'b0,4'd4,4'd9,4'd0,3'd0, 1'b1,3'd3, 1'b1,3'd3,4'd4,16'h2222, 1'b0, 2'd1,16'h0003, 2'd0,16'h0000, "R6  "},
        '{1'b0,1'b0,4'd4,4'd8,4'd0,3'd0, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd0,16'h2222, 2'd1,16'h0002, "R9  "},
        '{1'b0,1'b0,4'd8,4'd8,4'd0,3'd0, 1'b1,3'd2, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd1,16'h0002, 2'd1,16'h0002, "R4  "},
        '{1'b0,1'b0,4'd8,4'd9,4'd0,3'd0, 1'b0,3'd0, 1'b1,3'd5,4'd8,16'h3333, 1'b0, 2'd2,16'h0002, 2'd0,16'h0000, "R4  "},
        '{1'b1,1'b1,4'd8,4'd9,4'd9,3'd4, 1'b0,3'd0, 1'b1,3'd2,4'd8,16'h4444, 1'b1, 2'd2,16'h0002, 2'd0,16'h0000, "R6  "},
        '{1'b0,1'b0,4'd8,4'd9,4'd0,3'd0, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd0,16'h4444, 2'd0,16'h0000, "R7  "},
        '{1'b0,1'b0,4'd4,4'd15,4'd0,3'd0,1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd0,16'h2222, 2'd0,16'h0000, "R7  "},
        '{1'b1,1'b1,4'd5,4'd4,4'd5,3'd6, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd0,16'h0000, 2'd0,16'h2222, "R3  "},
        '{1'b1,1'b1,4'd5,4'd5,4'd5,3'd7, 1'b1,3'd6, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd1,16'h0006, 2'd1,16'h0006, "R10 "},
        '{1'b0,1'b0,4'd5,4'd4,4'd0,3'd0, 1'b0,3'd0, 1'b1,3'd7,4'd5,16'h5555, 1'b0, 2'd1,16'h0007, 2'd0,16'h2222, "R10 "},
        '{1'b1,1'b0,4'd5,4'd9,4'd9,3'd1, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd0,16'h5555, 2'd0,16'h0000, "R6  "},
        '{1'b0,1'b0,4'd9,4'd5,4'd0,3'd0, 1'b0,3'd0, 1'b0,3'd0,4'd0,16'h0000, 1'b0, 2'd0,16'h0000, 2'd0,16'h5555, "R3  "}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              iss_valid = 1'b0, iss_dst_en = 1'b0;
    logic [IDX_W-1:0]  iss_src0 = '0, iss_src1 = '0, iss_dst = '0, cmt_reg = '0;
    logic [TAG_W-1:0]  iss_tag = '0, res_tag = '0, cmt_tag = '0;
    logic              res_valid = 1'b0, cmt_valid = 1'b0, flush = 1'b0;
    logic [DATA_W-1:0] cmt_value = '0;
    logic [1:0]        src0_kind, src1_kind;
    logic [DATA_W-1:0] src0_value, src1_value;
    logic [TAG_W-1:0]  src0_tag, src1_tag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    reg_status_table #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_src0(iss_src0), .iss_src1(iss_src1),
        .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .res_valid(res_valid), .res_tag(res_tag),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_reg(cmt_reg), .cmt_value(cmt_value),
        .flush(flush),
        .src0_kind(src0_kind), .src0_value(src0_value), .src0_tag(src0_tag),
        .src1_kind(src1_kind), .src1_value(src1_value), .src1_tag(src1_tag)
    );

    task automatic check_src(input string req, input int step, input int port,
                             input logic [1:0] k, input logic [DATA_W-1:0] v,
                             input logic [TAG_W-1:0] t,
                             input logic [1:0] ek, input logic [15:0] ep);
        logic [15:0] got;
        got = (k == 2'd0) ? v : {13'b0, t};
        n_run++;
        if (k !== ek || got !== ep) begin
            n_fail++;
            $display("FAIL %s step %0d src%0d: kind %0d payload %h, expected kind %0d payload %h",
                     req, step, port, k, got, ek, ep);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_dst_en = 1'b0; res_valid = 1'b0;
        cmt_valid = 1'b0; flush = 1'b0;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state through both lookups
        iss_src0 = 4'd15; iss_src1 = 4'd0;
        #1;
        check_src("R1", -1, 0, src0_kind, src0_value, src0_tag, 2'd0, 16'h0000);
        check_src("R1", -1, 1, src1_kind, src1_value, src1_tag, 2'd0, 16'h0000);

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            iss_valid  = TBL[i].iv;  iss_dst_en = TBL[i].de;
            iss_src0   = TBL[i].s0;  iss_src1   = TBL[i].s1;
            iss_dst    = TBL[i].d;   iss_tag    = TBL[i].tg;
            res_valid  = TBL[i].rv;  res_tag    = TBL[i].rt;
            cmt_valid  = TBL[i].cv;  cmt_tag    = TBL[i].ct;
            cmt_reg    = TBL[i].cr;  cmt_value  = TBL[i].cval;
            flush      = TBL[i].fl;
            #1;
            check_src(string'(TBL[i].req), i, 0, src0_kind, src0_value, src0_tag, TBL[i].k0, TBL[i].p0);
            check_src(string'(TBL[i].req), i, 1, src1_kind, src1_value, src1_tag, TBL[i].k1, TBL[i].p1);
        end

        // R1: reset mid-run clears committed values and states
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        iss_src0 = 4'd5; iss_src1 = 4'd8;
        #1;
        check_src("R1", 99, 0, src0_kind, src0_value, src0_tag, 2'd0, 16'h0000);
        check_src("R1", 99, 1, src1_kind, src1_value, src1_tag, 2'd0, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule